// File: doc/BRIEF.md
# Pause Hold Timer for a Full-Duplex MAC Transmitter

This block keeps a MAC transmitter from sending data frames for a while after a flow-control PAUSE frame has been received. A frame detector elsewhere gives it a one-cycle pause request together with a 16-bit hold length. The hold length is counted in slot times. The block at once asks the transmitter for a graceful stop, which lets the frame already on the wire finish. It then waits for the transmitter to report that it is idle.

The hold count starts only once the transmitter is idle, not when the request arrives. At that moment a sticky stop-complete interrupt flag is raised and a pause status bit goes high. Each slot-time tick then advances the count by one. When the count reaches the requested length, the stop request and the status bit drop together, and data transmission may resume.

If a new request arrives during a hold, it replaces the target length and starts the count again from zero. A length of zero ends the hold as soon as the transmitter is idle.

Top module: `pause_hold_timer`

## Requirements
- R1: After a synchronous reset, `gstop_req`, `pause_active` and `stop_irq` are all 0.
- R2: A `pause_req` sampled while no hold is in progress sets `gstop_req` on the following cycle. `gstop_req` stays high until the hold ends.
- R3: While `gstop_req` is high and the transmitter has not yet been seen idle, a cycle with `tx_idle` high sets `stop_irq` on the next cycle. If the target length is nonzero, `pause_active` also goes high on that next cycle.
- R4: Slot ticks sampled before `tx_idle` has been seen during a hold are not counted. The hold still needs the full number of ticks after the stop.
- R5: While `pause_active` is high, each sampled `slot_tick` adds one to the count. On the cycle after the tick that brings the count to the target, `gstop_req` and `pause_active` both fall. One tick fewer does not end the hold.
- R6: With a target length of 0, `gstop_req` falls on the cycle after `tx_idle` is sampled. `pause_active` never rises, and `stop_irq` is still set.
- R7: A `pause_req` sampled during a hold loads its `pause_dur` as the new target. Once counting has begun, the request also restarts the count from zero, and it takes priority over a tick sampled in the same cycle. A new target of 0 ends the hold on the next cycle. A request and `tx_idle` sampled together before the stop use the new target.
- R8: `stop_irq` stays high until `irq_clr` is sampled high. A set event and a clear in the same cycle leave the flag at 1.
- R9: `pause_active` is never high while `gstop_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_req | input | 1 | One-cycle pulse: a PAUSE frame was accepted |
| pause_dur | input | 16 | Hold length in slot times, valid with `pause_req` |
| slot_tick | input | 1 | One-cycle pulse per elapsed slot time |
| tx_idle | input | 1 | High when the transmitter has no frame in progress |
| irq_clr | input | 1 | Write-one-to-clear pulse for `stop_irq` |
| gstop_req | output | 1 | Graceful stop request to the transmitter |
| stop_irq | output | 1 | Sticky flag: transmitter has stopped for a pause |
| pause_active | output | 1 | High while the transmitter is held by a pause |

## Verification
All three outputs are registered from the next state, so a wrong phase or a wrong count shows on the pins one cycle after the offending input is sampled. A count that is off by one shifts the falling edge of `gstop_req` by exactly one slot tick. A reload that fails to clear the count ends the hold early, within the new target's number of ticks. A phase that reacts to ticks before the stop shows up as a hold that ends too soon after `tx_idle`, while a lost idle event leaves `stop_irq` low on the cycle after `tx_idle`. The bench compares every output on every cycle against a model built from the requirements, so each of these faults is reported on the cycle it first appears.

// File: rtl/pht_pkg.sv
package pht_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2
  } ph_state_t;
endpackage

// File: rtl/pht_slot_counter.sv
module pht_slot_counter #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] dur_in,
  input  logic             restart,
  input  logic             step,
  input  logic             active,
  output logic             tgt_zero,
  output logic             reach
);
  localparam int SUM_W = DUR_W + 1;

  logic [DUR_W-1:0] tgt_q;
  logic [DUR_W-1:0] cnt_q;
  logic [SUM_W-1:0] cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) tgt_q <= dur_in;
      if (restart)   cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + SUM_W'(1);
    reach    = (cnt_inc == {1'b0, tgt_q});
    tgt_zero = (tgt_q == '0);
  end

  // R5: while holding, the count never reaches or passes the target
  assert_cnt_below_target_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < tgt_q));

  // R7: a restart always leaves the count at zero
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/pht_irq_flag.sv
module pht_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R8: set wins over a simultaneous clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R8: a clear alone drops the flag
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);

  // R8: the flag never rises without a set event
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set));
endmodule

// File: rtl/pht_ctrl.sv
module pht_ctrl
  import pht_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pause_req,
  input  logic dur_zero,
  input  logic tgt_zero,
  input  logic reach,
  input  logic tx_idle,
  input  logic slot_tick,
  output logic load,
  output logic restart,
  output logic step,
  output logic set_irq,
  output logic hold_active,
  output logic gstop_req,
  output logic pause_active
);
  ph_state_t state_q, state_d;
  logic      eff_zero;

  always_comb begin
    state_d  = state_q;
    load     = pause_req;
    restart  = 1'b0;
    step     = 1'b0;
    set_irq  = 1'b0;
    eff_zero = pause_req ? dur_zero : tgt_zero;
    unique case (state_q)
      PH_IDLE: begin
        if (pause_req) state_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (tx_idle) begin
          set_irq = 1'b1;
          if (eff_zero) begin
            state_d = PH_IDLE;
          end else begin
            state_d = PH_HOLD;
            restart = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (pause_req) begin
          if (dur_zero) state_d = PH_IDLE;
          else          restart = 1'b1;
        end else if (slot_tick) begin
          if (reach) state_d = PH_IDLE;
          else       step    = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PH_IDLE;
      gstop_req    <= 1'b0;
      pause_active <= 1'b0;
    end else begin
      state_q      <= state_d;
      gstop_req    <= (state_d != PH_IDLE);
      pause_active <= (state_d == PH_HOLD);
    end
  end

  assign hold_active = (state_q == PH_HOLD);

  // R2: the stop request only rises after a pause request
  assert_gstop_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(gstop_req) |-> $past(pause_req));

  // R9: the status bit implies the stop request
  assert_status_implies_stop_R9: assert property (@(posedge clk) disable iff (rst)
    pause_active |-> gstop_req);

  // R3: the status bit only rises after the transmitter was seen idle
  assert_status_after_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_active) |-> $past(tx_idle && gstop_req));

  // R5: the hold ends only through a tick or a zero-length reload
  assert_hold_end_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pause_active) |-> $past(slot_tick || pause_req));
endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pause_req,
  input  logic [DUR_W-1:0] pause_dur,
  input  logic             slot_tick,
  input  logic             tx_idle,
  input  logic             irq_clr,
  output logic             gstop_req,
  output logic             stop_irq,
  output logic             pause_active
);
  logic load, restart, step, set_irq, hold_active;
  logic tgt_zero, reach, dur_zero;

  assign dur_zero = (pause_dur == '0);

  pht_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pause_req    (pause_req),
    .dur_zero     (dur_zero),
    .tgt_zero     (tgt_zero),
    .reach        (reach),
    .tx_idle      (tx_idle),
    .slot_tick    (slot_tick),
    .load         (load),
    .restart      (restart),
    .step         (step),
    .set_irq      (set_irq),
    .hold_active  (hold_active),
    .gstop_req    (gstop_req),
    .pause_active (pause_active)
  );

  pht_slot_counter #(.DUR_W(DUR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .dur_in   (pause_dur),
    .restart  (restart),
    .step     (step),
    .active   (hold_active),
    .tgt_zero (tgt_zero),
    .reach    (reach)
  );

  pht_irq_flag u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (set_irq),
    .clr  (irq_clr),
    .flag (stop_irq)
  );

  // R6: the stop request never drops while the transmitter was not yet idle
  assert_no_early_release_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(gstop_req) && !$past(pause_active)) |-> $past(tx_idle));
endmodule

// File: tb/sim_pause_hold_timer.sv
module sim_pause_hold_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DUR_W      = 16;
  localparam int WD_LIMIT   = 50000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pause_req = 1'b0;
  logic [DUR_W-1:0] pause_dur = '0;
  logic             slot_tick = 1'b0;
  logic             tx_idle = 1'b0;
  logic             irq_clr = 1'b0;
  logic             gstop_req, stop_irq, pause_active;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state: 0 idle, 1 waiting for stop, 2 holding
  int               m_st;
  logic [DUR_W-1:0] m_tgt, m_cnt;
  logic             m_gs, m_ps, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_hold_timer #(.DUR_W(DUR_W)) u0 (
    .clk(clk), .rst(rst), .pause_req(pause_req), .pause_dur(pause_dur),
    .slot_tick(slot_tick), .tx_idle(tx_idle), .irq_clr(irq_clr),
    .gstop_req(gstop_req), .stop_irq(stop_irq), .pause_active(pause_active)
  );

  task automatic model_update();
    logic             set_i;
    logic [DUR_W-1:0] t;
    set_i = 1'b0;
    if (rst) begin
      m_st = 0; m_tgt = '0; m_cnt = '0; m_gs = 0; m_ps = 0; m_irq = 0;
      return;
    end
    case (m_st)
      0: if (pause_req) begin m_tgt = pause_dur; m_st = 1; m_gs = 1; end
      1: begin
        if (tx_idle) begin
          set_i = 1'b1;
          t = pause_req ? pause_dur : m_tgt;
          m_tgt = t;
          if (t == 0) begin m_st = 0; m_gs = 0; end
          else begin m_st = 2; m_cnt = '0; m_ps = 1; end
        end else if (pause_req) m_tgt = pause_dur;
      end
      default: begin
        if (pause_req) begin
          m_tgt = pause_dur;
          if (pause_dur == 0) begin m_st = 0; m_gs = 0; m_ps = 0; end
          else m_cnt = '0;
        end else if (slot_tick) begin
          if (m_cnt + 1'b1 == m_tgt) begin m_st = 0; m_gs = 0; m_ps = 0; end
          else m_cnt = m_cnt + 1'b1;
        end
      end
    endcase
    if (set_i) m_irq = 1'b1;
    else if (irq_clr) m_irq = 1'b0;
  endtask

  task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {gstop,active,irq} act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with the given inputs, then compare against the model
  task automatic drive(input logic pr, input logic [DUR_W-1:0] d, input logic tk,
                       input logic idle, input logic clr, input string req);
    pause_req = pr; pause_dur = d; slot_tick = tk; tx_idle = idle; irq_clr = clr;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check3(req, {gstop_req, pause_active, stop_irq}, {m_gs, m_ps, m_irq});
    pause_req = 0; slot_tick = 0; irq_clr = 0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'd20240611);
    // R1 reset
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, "R1");
    drive(1, 5, 1, 1, 1, "R1");
    rst = 1'b0;
    check3("R1", {gstop_req, pause_active, stop_irq}, 3'b000);

    // R2 request, R4 early ticks ignored, R3 stop, R5 three ticks
    drive(1, 3, 0, 0, 0, "R2");
    check3("R2", {gstop_req, pause_active, stop_irq}, 3'b100);
    drive(0, 0, 1, 0, 0, "R4");
    drive(0, 0, 1, 0, 0, "R4");
    drive(0, 0, 0, 1, 0, "R3");
    check3("R3", {gstop_req, pause_active, stop_irq}, 3'b111);
    drive(0, 0, 1, 1, 0, "R5");
    drive(0, 0, 1, 1, 0, "R5");
    check3("R5", {gstop_req, pause_active, stop_irq}, 3'b111);
    drive(0, 0, 0, 1, 0, "R5");
    drive(0, 0, 1, 1, 0, "R5");
    check3("R5", {gstop_req, pause_active, stop_irq}, 3'b001);

    // R8 clear, R6 zero length
    drive(0, 0, 0, 0, 1, "R8");
    check3("R8", {gstop_req, pause_active, stop_irq}, 3'b000);
    drive(1, 0, 0, 0, 0, "R6");
    drive(0, 0, 1, 0, 0, "R6");
    drive(0, 0, 0, 1, 0, "R6");
    check3("R6", {gstop_req, pause_active, stop_irq}, 3'b001);

    // R7 reload while waiting, while holding (tick same cycle), zero reload
    drive(1, 2, 0, 0, 0, "R7");
    drive(1, 4, 0, 0, 0, "R7");
    drive(0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 1, 0, "R7");
    drive(1, 2, 1, 1, 0, "R7");
    drive(0, 0, 1, 1, 0, "R7");
    check3("R7", {gstop_req, pause_active, stop_irq}, 3'b111);
    drive(0, 0, 1, 1, 0, "R7");
    check3("R7", {gstop_req, pause_active, stop_irq}, 3'b001);
    drive(1, 5, 0, 0, 0, "R7");
    drive(0, 0, 0, 1, 0, "R7");
    drive(1, 0, 0, 1, 0, "R7");
    check3("R7", {gstop_req, pause_active, stop_irq}, 3'b001);

    // R8 set and clear in the same cycle
    drive(0, 0, 0, 0, 1, "R8");
    drive(1, 1, 0, 0, 0, "R8");
    drive(0, 0, 0, 1, 1, "R8");
    check3("R8", {gstop_req, pause_active, stop_irq}, 3'b111);
    drive(0, 0, 1, 1, 0, "R9");
    check3("R9", {gstop_req, pause_active, stop_irq}, 3'b001);

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 20) == 0, DUR_W'($urandom % 7), ($urandom % 3) == 0,
            ($urandom % 2) == 0, ($urandom % 25) == 0, "R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule